// File: doc/BRIEF.md
# UART Baud Tick Generator

This block derives the two timing strobes that an asynchronous serial port needs from the system clock. A 12-bit divisor is programmed through two byte-wide writes. A down-counter steps once per system clock. Each time it sits at zero it raises a one-cycle receive tick and then reloads from the divisor. The receive tick therefore repeats every divisor+1 clocks, and the receiver's oversampling logic uses it directly.

A second stage counts receive ticks and raises a transmit bit strobe on every 16th tick. When double-speed mode is set, it does so on every 8th tick instead, which doubles the transmit bit rate. The upper four divisor bits are staged by a high-byte write. They reach the counter only when the low byte is written, and that write also restarts the count at once. Changing the speed mode or disabling the transmitter clears the transmit prescaler, so the next transmit strobe starts from a known phase.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the divisor is 0 and double-speed is off. rx_tick_o is high in every cycle, and tx_tick_o is low in the first cycle after reset.
- R2: A low-byte write (wr_lo_i) loads divisor D = {staged high nibble, wr_data_i[7:0]} into the counter at that clock edge. The first rx_tick_o after the write comes exactly D cycles after the write edge, where 0 cycles means the first cycle after the edge.
- R3: A high-byte write (wr_hi_i) stages only wr_data_i[3:0] and leaves the running tick period unchanged. The staged bits form divisor bits [11:8] at the next low-byte write.
- R4: With divisor D, consecutive rx_tick_o pulses are exactly D+1 cycles apart, including D values above 255.
- R5: With divisor 0, rx_tick_o is high in every cycle.
- R6: With double-speed off, tx_tick_o pulses only in cycles where rx_tick_o is high, and consecutive pulses are 16*(D+1) cycles apart.
- R7: With double-speed on, consecutive tx_tick_o pulses are 8*(D+1) cycles apart.
- R8: A control write (wr_ctrl_i) sets double-speed from wr_data_i[0]. If the value changes, tx_tick_o stays low in the cycle after the write edge and the prescaler clears. Counting from the second cycle after the write edge, the first tx_tick_o falls on the 8th rx tick (double-speed on) or the 16th (double-speed off).
- R9: While tx_en_i is low, tx_tick_o stays low and the prescaler is held clear. Counting from the first cycle in which tx_en_i is high again, the first tx_tick_o falls on the 16th rx tick, or the 8th with double-speed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_hi_i | input | 1 | Stage divisor bits [11:8] from wr_data_i[3:0] |
| wr_lo_i | input | 1 | Write divisor bits [7:0] and reload the counter |
| wr_ctrl_i | input | 1 | Write double-speed bit from wr_data_i[0] |
| wr_data_i | input | 8 | Write data |
| tx_en_i | input | 1 | Transmitter enable; low holds the prescaler clear |
| rx_tick_o | output | 1 | Raw baud tick, one cycle wide |
| tx_tick_o | output | 1 | Transmit bit strobe, one cycle wide |

## Verification
Inputs are driven at the falling edge and outputs are sampled at later falling edges, so each result is read in the cycle the requirements place it. After a low-byte write, the bench counts the falling edges from the write edge to the first receive tick and expects exactly D of them. Tick periods are measured as gaps between recorded tick cycles. After a speed-mode change, transmit strobes are counted in receive ticks starting at the second falling edge after the write, because the prescaler clears one cycle later. After a transmitter re-enable, counting starts in the first cycle with the enable high.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int DIV_W  = 12;
  localparam int BYTE_W = 8;
  localparam int HI_W   = DIV_W - BYTE_W;
  localparam int OVS_NORM = 16;
  localparam int OVS_FAST = 8;
  localparam int PRE_W  = $clog2(OVS_NORM);
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_ctrl_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output div_t              div_o,
  output logic              load_o,
  output div_t              load_val_o,
  output logic              dbl_o
);
  logic [HI_W-1:0] hi_q;
  div_t            div_q;
  logic            dbl_q;

  assign load_val_o = {hi_q, wr_data_i};
  assign load_o     = wr_lo_i;
  assign div_o      = div_q;
  assign dbl_o      = dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      div_q <= '0;
      dbl_q <= 1'b0;
    end else begin
      if (wr_hi_i)   hi_q  <= wr_data_i[HI_W-1:0];
      if (wr_lo_i)   div_q <= load_val_o;
      if (wr_ctrl_i) dbl_q <= wr_data_i[0];
    end
  end

  // R3
  hi_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> div_q == $past(div_q));
endmodule

// File: rtl/baud_down_cnt.sv
module baud_down_cnt
  import baud_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  div_t div_i,
  input  logic load_i,
  input  div_t load_val_i,
  output logic tick_o
);
  div_t cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_o)  cnt_q <= div_i;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // R2
  force_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  // R4
  zero_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> cnt_q == $past(div_i));
  // R4
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/baud_tx_prescale.sv
module baud_tx_prescale
  import baud_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dbl_i,
  input  logic tx_en_i,
  output logic tx_tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_val;
  logic             dbl_seen_q;
  logic             clr;

  assign last_val  = dbl_i ? PRE_W'(OVS_FAST - 1) : PRE_W'(OVS_NORM - 1);
  assign clr       = !tx_en_i || (dbl_i != dbl_seen_q);
  assign tx_tick_o = tick_i && !clr && (pre_q == last_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      dbl_seen_q <= 1'b0;
    end else begin
      dbl_seen_q <= dbl_i;
      if (clr)         pre_q <= '0;
      else if (tick_i) pre_q <= (pre_q == last_val) ? '0 : pre_q + 1'b1;
    end
  end

  // R8
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i != dbl_seen_q) |=> pre_q == '0);
  // R9
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !tx_tick_o);
  // R7
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |-> pre_q <= last_val);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_gen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_ctrl_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  output logic              rx_tick_o,
  output logic              tx_tick_o
);
  div_t div;
  div_t load_val;
  logic load;
  logic dbl;

  baud_div_regs u_regs (
    .clk_i, .rst_ni, .wr_hi_i, .wr_lo_i, .wr_ctrl_i, .wr_data_i,
    .div_o(div), .load_o(load), .load_val_o(load_val), .dbl_o(dbl)
  );

  baud_down_cnt u_cnt (
    .clk_i, .rst_ni, .div_i(div), .load_i(load), .load_val_i(load_val),
    .tick_o(rx_tick_o)
  );

  baud_tx_prescale u_pre (
    .clk_i, .rst_ni, .tick_i(rx_tick_o), .dbl_i(dbl), .tx_en_i,
    .tx_tick_o
  );

  // R6
  tx_on_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |-> rx_tick_o);
endmodule

// File: tb/uart_baud_gen_tb_top.sv
module uart_baud_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_hi = 1'b0, wr_lo = 1'b0, wr_ctrl = 1'b0, tx_en = 1'b1;
  logic [7:0] wr_data = '0;
  logic rx_tick, tx_tick;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_baud_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wr_ctrl_i(wr_ctrl), .wr_data_i(wr_data), .tx_en_i(tx_en),
    .rx_tick_o(rx_tick), .tx_tick_o(tx_tick)
  );

  function automatic int ovs(input bit d);
    return d ? 8 : 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulses one write; returns at the first falling edge after the write edge.
  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_hi = (which == 0); wr_lo = (which == 1); wr_ctrl = (which == 2);
    @(negedge clk);
    wr_hi = 0; wr_lo = 0; wr_ctrl = 0;
  endtask

  // R2: falling edges from here to the first rx tick
  task automatic first_rx(input int d);
    int k = 0;
    while (!rx_tick && k < 5000) begin @(negedge clk); k++; end
    chk(k == d, "R2 first rx tick", k, d);
  endtask

  // R4/R6/R7: measure periods over n cycles
  task automatic observe(input int n, input int d, input bit dbl, input string rq);
    int last_rx = -1, last_tx = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_tick) chk(rx_tick, "R6 tx on rx", 0, 1);
      if (rx_tick) begin
        if (last_rx >= 0) chk(i - last_rx == d + 1, "R4 rx period", i - last_rx, d + 1);
        last_rx = i;
      end
      if (tx_tick) begin
        if (last_tx >= 0) chk(i - last_tx == (d + 1) * ovs(dbl), rq, i - last_tx, (d + 1) * ovs(dbl));
        last_tx = i;
      end
    end
  endtask

  // Counts rx ticks from the current sample up to and including the first tx tick.
  task automatic count_to_tx(input int exp, input string rq);
    int c = 0;
    for (int i = 0; i < 20000; i++) begin
      if (rx_tick) c++;
      if (tx_tick) break;
      @(negedge clk);
    end
    chk(c == exp, rq, c, exp);
  endtask

  task automatic set_div(input int d);
    wr(0, 8'(d >> 8));
    wr(1, 8'(d));
    first_rx(d);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit dbl = 0;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rx_tick == 1'b1, "R1 rx after reset", rx_tick, 1);
    chk(tx_tick == 1'b0, "R1 tx after reset", tx_tick, 0);
    // R5: divisor 0 ticks every cycle
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); hits += rx_tick; end
      chk(hits == 40, "R5 tick every cycle", hits, 40);
    end
    observe(80, 0, 0, "R6 tx period");

    // random divisors and modes
    for (int it = 0; it < 8; it++) begin
      int d = $urandom % 24;
      bit nd = 1'($urandom % 2);
      if (nd != dbl) begin
        wr(2, {7'd0, nd});
        dbl = nd;
      end
      set_div(d);
      observe((d + 1) * ovs(dbl) * 3 + 4, d, dbl, dbl ? "R7 tx period" : "R6 tx period");
    end

    // R3: high write alone leaves period unchanged
    set_div(5);
    wr(0, 8'hF3);
    observe(60, 5, dbl, "R3 period kept");
    wr(1, 8'h00);
    first_rx(12'h300);
    observe(800, 12'h300, dbl, "R3 staged nibble");
    set_div(12'h102);

    // R8: mode change clears prescaler
    set_div(2);
    wr(2, {7'd0, ~dbl});
    dbl = ~dbl;
    chk(tx_tick == 1'b0, "R8 gated after change", tx_tick, 0);
    @(negedge clk);
    count_to_tx(ovs(dbl), "R8 first tx after change");
    wr(2, {7'd0, ~dbl});
    dbl = ~dbl;
    @(negedge clk);
    count_to_tx(ovs(dbl), "R8 first tx after change back");

    // R9: tx disable
    @(negedge clk); tx_en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); seen += tx_tick; end
      chk(seen == 0, "R9 no tx while disabled", seen, 0);
    end
    @(negedge clk); tx_en = 1'b1; #1;
    count_to_tx(ovs(dbl), "R9 first tx after enable");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule